// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block turns the operation code and the function field of the instruction in flight into the set of steering signals that a single-cycle 32-bit RISC datapath needs in the same cycle. It is purely combinational. Seven instructions are recognised: register add, register subtract, OR with an immediate, load word, store word, branch on equal and an unconditional jump.

Decoding is split in two stages. A main stage matches the operation code against the six supported classes, with one bitwise-equality comparator per class. All register-format instructions share a single row in this stage. A local stage then reads the function field and resolves the ALU operation for that shared row. Any encoding outside the supported set, including a register-format instruction with an unknown function value, gives an all-zero output. An all-zero output writes nothing and does not redirect the program counter.

Top module: `sc_ctrl_decode`

## Requirements
- R1: Operation code 000000 with function 100000 (add) gives dst_rd_o=1, reg_we_o=1, alu_op_o=3'b010, and all other outputs 0.
- R2: Operation code 000000 with function 100010 (subtract) gives dst_rd_o=1, reg_we_o=1, alu_op_o=3'b110, and all other outputs 0.
- R3: Operation code 000000 with any other function value drives every output to 0.
- R4: Operation code 001101 (OR immediate) gives reg_we_o=1, b_imm_o=1, alu_op_o=3'b001 and zero extension (sext_o=0). All other outputs are 0.
- R5: Operation code 100011 (load word) gives reg_we_o=1, b_imm_o=1, wb_mem_o=1, sext_o=1, alu_op_o=3'b010, and all other outputs 0.
- R6: Operation code 101011 (store word) gives mem_we_o=1, b_imm_o=1, sext_o=1, alu_op_o=3'b010, reg_we_o=0, and all other outputs 0.
- R7: Operation code 000100 (branch on equal) gives br_eq_o=1, alu_op_o=3'b110, b_imm_o=0, and both write enables 0. All other outputs are 0.
- R8: Operation code 000010 (jump) gives jmp_o=1 and every other output 0.
- R9: Any operation code outside the six above drives every output to 0.
- R10: For every operation code other than 000000, the function field has no effect on any output.
- R11: No more than one of jmp_o, br_eq_o, mem_we_o and reg_we_o is 1 at any time. wb_mem_o=1 only occurs together with reg_we_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Operation code field, instruction bits 31..26 |
| fn_i | input | 6 | Function field, instruction bits 5..0 |
| dst_rd_o | output | 1 | Write-register select: 1 = rd field, 0 = rt field |
| b_imm_o | output | 1 | ALU second operand: 1 = extended immediate, 0 = register |
| wb_mem_o | output | 1 | Write-back source: 1 = data memory, 0 = ALU result |
| reg_we_o | output | 1 | Register file write enable |
| mem_we_o | output | 1 | Data memory write enable |
| br_eq_o | output | 1 | Take branch target when ALU result is zero |
| jmp_o | output | 1 | Select jump target for the next PC |
| sext_o | output | 1 | Immediate extension: 1 = sign, 0 = zero |
| alu_op_o | output | 3 | ALU operation: 010 add, 110 subtract, 001 OR, 000 idle |

## Verification
The assertions are evaluated whenever an input changes. They check the relations that must hold on every code: the write enables, branch and jump are mutually exclusive, a memory write-back implies a register write, a branch always subtracts two registers, and an unrecognised operation code leaves every output at zero. The exact output word for each instruction is shown only by the bench scenarios. These cover the directed encodings, register-format codes with foreign function values, and jumps and immediates paired with random function fields. Random codes are compared against a separately written expectation function.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;

  localparam int OPW  = 6;
  localparam int FNW  = 6;
  localparam int ALUW = 3;
  localparam int NCLS = 6;

  // class indices into the opcode table
  localparam int CLS_REG = 0;
  localparam int CLS_ORI = 1;
  localparam int CLS_LDW = 2;
  localparam int CLS_STW = 3;
  localparam int CLS_BEQ = 4;
  localparam int CLS_JMP = 5;

  localparam logic [OPW-1:0] OPC_REG = 6'b000000;
  localparam logic [OPW-1:0] OPC_ORI = 6'b001101;
  localparam logic [OPW-1:0] OPC_LDW = 6'b100011;
  localparam logic [OPW-1:0] OPC_STW = 6'b101011;
  localparam logic [OPW-1:0] OPC_BEQ = 6'b000100;
  localparam logic [OPW-1:0] OPC_JMP = 6'b000010;

  localparam logic [NCLS*OPW-1:0] OPC_TABLE =
    {OPC_JMP, OPC_BEQ, OPC_STW, OPC_LDW, OPC_ORI, OPC_REG};

  localparam logic [FNW-1:0] FN_ADD = 6'b100000;
  localparam logic [FNW-1:0] FN_SUB = 6'b100010;

  localparam logic [ALUW-1:0] ALU_IDLE = 3'b000;
  localparam logic [ALUW-1:0] ALU_ADD  = 3'b010;
  localparam logic [ALUW-1:0] ALU_SUB  = 3'b110;
  localparam logic [ALUW-1:0] ALU_OR   = 3'b001;

  // ALU request from the main stage; AK_FUNCT defers to the local stage
  typedef enum logic [2:0] {
    AK_NONE  = 3'd0,
    AK_FUNCT = 3'd1,
    AK_ADD   = 3'd2,
    AK_SUB   = 3'd3,
    AK_OR    = 3'd4
  } alu_kind_e;

  typedef struct packed {
    logic dst_rd;
    logic b_imm;
    logic wb_mem;
    logic reg_we;
    logic mem_we;
    logic br_eq;
    logic jmp;
    logic sext;
  } ctrl_t;

  localparam ctrl_t CTRL_ZERO = '0;

  function automatic logic [OPW-1:0] opc_at(input int k);
    return OPC_TABLE[k*OPW +: OPW];
  endfunction

  // bitwise-equality match: AND of per-bit XNORs
  function automatic logic code_match(input logic [OPW-1:0] a,
                                      input logic [OPW-1:0] b);
    return &(~(a ^ b));
  endfunction

  function automatic logic [ALUW-1:0] alu_code_of(input alu_kind_e k);
    case (k)
      AK_ADD:  return ALU_ADD;
      AK_SUB:  return ALU_SUB;
      AK_OR:   return ALU_OR;
      default: return ALU_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/sc_op_match.sv
module sc_op_match #(
  parameter int W = 6,
  parameter logic [W-1:0] PAT = '0
) (
  input  logic [W-1:0] code_i,
  output logic         hit_o
);
  logic [W-1:0] bit_eq;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_eq[i] = ~(code_i[i] ^ PAT[i]);
  end

  assign hit_o = &bit_eq;
endmodule

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_ctrl_pkg::*;
(
  input  logic [OPW-1:0]  op_i,
  output logic [NCLS-1:0] cls_hit_o,
  output ctrl_t           ctrl_o,
  output alu_kind_e       alu_kind_o
);
  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    sc_op_match #(.W(OPW), .PAT(opc_at(k))) u_match (
      .code_i (op_i),
      .hit_o  (cls_hit_o[k])
    );
  end

  always_comb begin
    ctrl_o     = CTRL_ZERO;
    alu_kind_o = AK_NONE;
    unique case (1'b1)
      cls_hit_o[CLS_REG]: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.reg_we = 1'b1;
        alu_kind_o    = AK_FUNCT;
      end
      cls_hit_o[CLS_ORI]: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.reg_we = 1'b1;
        alu_kind_o    = AK_OR;
      end
      cls_hit_o[CLS_LDW]: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.wb_mem = 1'b1;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.sext   = 1'b1;
        alu_kind_o    = AK_ADD;
      end
      cls_hit_o[CLS_STW]: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.mem_we = 1'b1;
        ctrl_o.sext   = 1'b1;
        alu_kind_o    = AK_ADD;
      end
      cls_hit_o[CLS_BEQ]: begin
        ctrl_o.br_eq  = 1'b1;
        alu_kind_o    = AK_SUB;
      end
      cls_hit_o[CLS_JMP]: begin
        ctrl_o.jmp    = 1'b1;
      end
      default: begin
        ctrl_o     = CTRL_ZERO;
        alu_kind_o = AK_NONE;
      end
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_ctrl_pkg::*;
(
  input  alu_kind_e       kind_i,
  input  logic [FNW-1:0]  fn_i,
  output logic [ALUW-1:0] alu_op_o,
  output logic            fn_known_o
);
  logic is_add, is_sub;

  sc_op_match #(.W(FNW), .PAT(FN_ADD)) u_add (.code_i(fn_i), .hit_o(is_add));
  sc_op_match #(.W(FNW), .PAT(FN_SUB)) u_sub (.code_i(fn_i), .hit_o(is_sub));

  assign fn_known_o = is_add | is_sub;

  always_comb begin
    if (kind_i == AK_FUNCT) begin
      if (is_add)      alu_op_o = ALU_ADD;
      else if (is_sub) alu_op_o = ALU_SUB;
      else             alu_op_o = ALU_IDLE;
    end else begin
      alu_op_o = alu_code_of(kind_i);
    end
  end
endmodule

// File: rtl/sc_ctrl_decode.sv
module sc_ctrl_decode
  import sc_ctrl_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output logic       dst_rd_o,
  output logic       b_imm_o,
  output logic       wb_mem_o,
  output logic       reg_we_o,
  output logic       mem_we_o,
  output logic       br_eq_o,
  output logic       jmp_o,
  output logic       sext_o,
  output logic [2:0] alu_op_o
);
  logic [NCLS-1:0] cls_hit;
  ctrl_t           main_ctrl;
  ctrl_t           final_ctrl;
  alu_kind_e       alu_kind;
  logic [ALUW-1:0] alu_code;
  logic            fn_known;
  logic            reg_bad_fn;   // register format with unsupported function

  sc_main_dec u_main (
    .op_i       (op_i),
    .cls_hit_o  (cls_hit),
    .ctrl_o     (main_ctrl),
    .alu_kind_o (alu_kind)
  );

  sc_alu_dec u_alu (
    .kind_i     (alu_kind),
    .fn_i       (fn_i),
    .alu_op_o   (alu_code),
    .fn_known_o (fn_known)
  );

  assign reg_bad_fn = cls_hit[CLS_REG] & ~fn_known;
  assign final_ctrl = reg_bad_fn ? CTRL_ZERO : main_ctrl;

  assign dst_rd_o = final_ctrl.dst_rd;
  assign b_imm_o  = final_ctrl.b_imm;
  assign wb_mem_o = final_ctrl.wb_mem;
  assign reg_we_o = final_ctrl.reg_we;
  assign mem_we_o = final_ctrl.mem_we;
  assign br_eq_o  = final_ctrl.br_eq;
  assign jmp_o    = final_ctrl.jmp;
  assign sext_o   = final_ctrl.sext;
  assign alu_op_o = alu_code;
endmodule

// File: rtl/sc_ctrl_decode_chk.sv
module sc_ctrl_decode_chk (
  input logic [5:0] op_i,
  input logic [5:0] fn_i,
  input logic       dst_rd_o,
  input logic       b_imm_o,
  input logic       wb_mem_o,
  input logic       reg_we_o,
  input logic       mem_we_o,
  input logic       br_eq_o,
  input logic       jmp_o,
  input logic       sext_o,
  input logic [2:0] alu_op_o
);
  logic known_op;
  assign known_op = (op_i == 6'b000000) || (op_i == 6'b001101) ||
                    (op_i == 6'b100011) || (op_i == 6'b101011) ||
                    (op_i == 6'b000100) || (op_i == 6'b000010);

  always_comb begin
    a_r11_exclusive: assert ($onehot0({jmp_o, br_eq_o, mem_we_o, reg_we_o}))
      else $error("R11 exclusive enables violated");
    a_r11_memwb_needs_we: assert (!wb_mem_o || reg_we_o)
      else $error("R11 memory write-back without register write");
    a_r7_branch_sub: assert (!br_eq_o || (alu_op_o == 3'b110 && !b_imm_o))
      else $error("R7 branch without register subtract");
    a_r8_jump_quiet: assert (!jmp_o || (alu_op_o == 3'b000 && !dst_rd_o && !b_imm_o && !sext_o))
      else $error("R8 jump with side outputs");
    a_r9_unknown_zero: assert (known_op ||
      ({dst_rd_o, b_imm_o, wb_mem_o, reg_we_o, mem_we_o, br_eq_o, jmp_o, sext_o, alu_op_o} == 11'd0))
      else $error("R9 unknown opcode drives outputs");
    a_r6_store_sext: assert (!mem_we_o || (sext_o && b_imm_o && alu_op_o == 3'b010))
      else $error("R6 store address path wrong");
  end
endmodule

bind sc_ctrl_decode sc_ctrl_decode_chk chk_i (.*);

// File: tb/sc_ctrl_decode_tb_top.sv
`timescale 1ns/1ps
module sc_ctrl_decode_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0] op, fn;
  logic dst_rd, b_imm, wb_mem, reg_we, mem_we, br_eq, jmp, sext;
  logic [2:0] alu_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sc_ctrl_decode dut_i (
    .op_i(op), .fn_i(fn),
    .dst_rd_o(dst_rd), .b_imm_o(b_imm), .wb_mem_o(wb_mem),
    .reg_we_o(reg_we), .mem_we_o(mem_we), .br_eq_o(br_eq),
    .jmp_o(jmp), .sext_o(sext), .alu_op_o(alu_op)
  );

  // packed order: dst_rd b_imm wb_mem reg_we mem_we br_eq jmp sext alu[2:0]
  function automatic logic [10:0] expect_word(input logic [5:0] o, input logic [5:0] f);
    case (o)
      6'b000000: begin
        if (f == 6'b100000)      return 11'b1_0_0_1_0_0_0_0_010;
        else if (f == 6'b100010) return 11'b1_0_0_1_0_0_0_0_110;
        else                     return 11'd0;
      end
      6'b001101: return 11'b0_1_0_1_0_0_0_0_001;
      6'b100011: return 11'b0_1_1_1_0_0_0_1_010;
      6'b101011: return 11'b0_1_0_0_1_0_0_1_010;
      6'b000100: return 11'b0_0_0_0_0_1_0_0_110;
      6'b000010: return 11'b0_0_0_0_0_0_1_0_000;
      default:   return 11'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [5:0] o, input logic [5:0] f);
    case (o)
      6'b000000: return (f == 6'b100000) ? "R1" : (f == 6'b100010) ? "R2" : "R3";
      6'b001101: return "R4";
      6'b100011: return "R5";
      6'b101011: return "R6";
      6'b000100: return "R7";
      6'b000010: return "R8";
      default:   return "R9";
    endcase
  endfunction

  task automatic apply_check(input logic [5:0] o, input logic [5:0] f, input string tag);
    logic [10:0] got, exp;
    @(negedge clk);
    op = o; fn = f;
    #1;
    got = {dst_rd, b_imm, wb_mem, reg_we, mem_we, br_eq, jmp, sext, alu_op};
    exp = expect_word(o, f);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", tag, o, f, got, exp);
    end
    // R11 checked at the ports on every vector
    checks++;
    if ($countones({jmp, br_eq, mem_we, reg_we}) > 1 || (wb_mem && !reg_we)) begin
      errors++;
      $display("FAIL R11 op=%b fn=%b actual=%b expected=exclusive", o, f, got);
    end
  endtask

  localparam logic [5:0] OPS [6] = '{6'b000000, 6'b001101, 6'b100011,
                                     6'b101011, 6'b000100, 6'b000010};

  initial begin
    op = '0; fn = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    apply_check(6'b000000, 6'b100000, "R1");
    apply_check(6'b000000, 6'b100010, "R2");
    apply_check(6'b000000, 6'b000000, "R3");
    apply_check(6'b000000, 6'b100001, "R3");
    apply_check(6'b000000, 6'b111111, "R3");
    apply_check(6'b001101, 6'b000000, "R4");
    apply_check(6'b100011, 6'b000000, "R5");
    apply_check(6'b101011, 6'b000000, "R6");
    apply_check(6'b000100, 6'b000000, "R7");
    apply_check(6'b000010, 6'b000000, "R8");
    apply_check(6'b000010, 6'b100010, "R8");
    apply_check(6'b000011, 6'b000000, "R9");
    apply_check(6'b111111, 6'b100000, "R9");
    apply_check(6'b001100, 6'b100000, "R9");
    // R10: function field has no effect outside register format
    for (int k = 1; k < 6; k++) begin
      apply_check(OPS[k], 6'b100000, "R10");
      apply_check(OPS[k], 6'b100010, "R10");
      apply_check(OPS[k], 6'($urandom), "R10");
    end

    for (int n = 0; n < 3000; n++) begin
      logic [5:0] o, f;
      o = ($urandom % 2 == 0) ? OPS[$urandom % 6] : 6'($urandom);
      case ($urandom % 3)
        0: f = 6'b100000;
        1: f = 6'b100010;
        default: f = 6'($urandom);
      endcase
      apply_check(o, f, (o != 6'b000000) && (o inside {OPS[1], OPS[2], OPS[3], OPS[4], OPS[5]})
                        ? "R10" : req_of(o, f));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before stimulus completed");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule